// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Codec

This block guards 32-bit memory words with seven check bits. On the write side a purely combinational encoder turns a data word into a 39-bit codeword: the data bits pass through unchanged and the seven check bits are appended above them. On the read side the decoder takes a 39-bit codeword qualified by a valid strobe. It recomputes the check bits, forms a 7-bit syndrome, repairs any single flipped bit and reports what it found. The corrected data and its status flags appear on registered outputs one clock after the strobe. Only reads pay this one cycle of latency.

The parity-check matrix uses only odd-weight columns, and it keeps them as light as possible. Each check bit owns a unit column. Each data bit owns a distinct weight-3 column. A single error therefore always leaves an odd-weight syndrome, and any pair of errors leaves an even-weight syndrome that is not zero. That difference is the whole of the double-error detection. Of the 35 weight-3 patterns, three are left out so that every check bit covers either 13 or 14 data bits.

Top module: `secded_codec`

## Requirements
- R1: `enc_code[31:0]` equals `enc_data`. `enc_code[32+j]` is the XOR of the data bits whose column has bit j set. Data bit i's column is the i-th (counting from 0) 7-bit value of popcount 3 in ascending numeric order, with the values 7, 56 and 97 skipped. Check bit j's column is the unit value 1<<j.
- R2: Every check bit covers 13 or 14 of the 32 data bits.
- R3: A codeword with no error gives `dec_data` equal to its data field, with both flags low.
- R4: A codeword with exactly one data bit flipped gives the original data with `dec_corrected` high and `dec_uncorrectable` low.
- R5: A codeword with exactly one check bit flipped gives `dec_data` equal to the unchanged data field with `dec_corrected` high and `dec_uncorrectable` low.
- R6: A codeword with any two bits flipped gives `dec_uncorrectable` high and `dec_corrected` low.
- R7: A nonzero syndrome of odd weight that equals no column gives `dec_uncorrectable` high, `dec_corrected` low and the data field unchanged. Flipping check bits 0, 1 and 2 gives the syndrome 7, which is such a case.
- R8: `dec_valid`, `dec_data` and both flags update on the first rising clock edge after `dec_valid_in` is sampled high. `dec_valid` is `dec_valid_in` delayed by one cycle.
- R9: While `dec_valid` is low both flags are low. During reset every decoder output is zero.
- R10: `dec_corrected` and `dec_uncorrectable` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_data | input | 32 | Data word to encode |
| enc_code | output | 39 | Codeword: check bits in [38:32], data in [31:0] |
| dec_valid_in | input | 1 | Qualifies `dec_code` |
| dec_code | input | 39 | Codeword read back from storage |
| dec_valid | output | 1 | Registered output valid |
| dec_data | output | 32 | Corrected data word |
| dec_corrected | output | 1 | A single-bit error was repaired |
| dec_uncorrectable | output | 1 | The error is beyond repair |

## Verification
The hardest case to reach from the ports is a syndrome of odd weight that matches no column. No single or double error can produce one. The stimulus builds these cases on purpose from valid codewords: it flips the three check bits whose unit columns add up to an excluded weight-3 pattern, and it flips five check bits to get a weight-5 syndrome. The rest of the sweep tries every single-bit flip position on each test word, plus a random sample of distinct bit pairs. The bench predicts each result only from the injected error pattern.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DW = 32;
  localparam int CW = 7;
  localparam int NW = DW + CW;
  localparam int COLW = 3;
  localparam int VMAX = 1 << CW;

  function automatic int bit_weight(input logic [CW-1:0] v);
    int n;
    n = 0;
    for (int b = 0; b < CW; b++) n += int'(v[b]);
    return n;
  endfunction

  function automatic logic excluded(input logic [CW-1:0] v);
    return (v == 7'h07) || (v == 7'h38) || (v == 7'h61);
  endfunction

  function automatic logic [CW-1:0] column(input int idx);
    logic [CW-1:0] found;
    int k;
    found = '0;
    k = 0;
    if (idx >= DW) begin
      found = CW'(1) << (idx - DW);
    end else begin
      for (int v = 1; v < VMAX; v++) begin
        if (bit_weight(CW'(v)) == COLW && !excluded(CW'(v))) begin
          if (k == idx) found = CW'(v);
          k++;
        end
      end
    end
    return found;
  endfunction

  function automatic logic [DW-1:0] row_mask(input int row);
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) begin
      logic [CW-1:0] c;
      c = column(i);
      m[i] = c[row];
    end
    return m;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] check_o
);
  for (genvar j = 0; j < CW; j++) begin : g_row
    localparam logic [DW-1:0] MASK = row_mask(j);
    assign check_o[j] = ^(data_i & MASK);
  end
endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome
  import secded_pkg::*;
(
  input  logic [NW-1:0] code_i,
  output logic [CW-1:0] syn_o
);
  logic [CW-1:0] recomputed;

  secded_enc u_recalc (
    .data_i (code_i[DW-1:0]),
    .check_o(recomputed)
  );

  assign syn_o = recomputed ^ code_i[NW-1:DW];
endmodule

// File: rtl/secded_locate.sv
module secded_locate
  import secded_pkg::*;
(
  input  logic [CW-1:0] syn_i,
  output logic [NW-1:0] match_o,
  output logic          single_o,
  output logic          multi_o
);
  for (genvar i = 0; i < NW; i++) begin : g_col
    localparam logic [CW-1:0] COL = column(i);
    assign match_o[i] = (syn_i == COL);
  end

  logic nonzero;
  assign nonzero  = |syn_i;
  assign single_o = nonzero & (|match_o);
  assign multi_o  = nonzero & ~(|match_o);
endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] enc_data,
  output logic [NW-1:0] enc_code,
  input  logic          dec_valid_in,
  input  logic [NW-1:0] dec_code,
  output logic          dec_valid,
  output logic [DW-1:0] dec_data,
  output logic          dec_corrected,
  output logic          dec_uncorrectable
);
  logic [CW-1:0] enc_chk;
  logic [CW-1:0] syn_w;
  logic [NW-1:0] match_w;
  logic          single_w;
  logic          multi_w;
  logic [DW-1:0] fixed_w;

  secded_enc u_enc (
    .data_i (enc_data),
    .check_o(enc_chk)
  );
  assign enc_code = {enc_chk, enc_data};

  secded_syndrome u_syn (
    .code_i(dec_code),
    .syn_o (syn_w)
  );

  secded_locate u_loc (
    .syn_i   (syn_w),
    .match_o (match_w),
    .single_o(single_w),
    .multi_o (multi_w)
  );

  // Only data-position matches touch the data; a check-bit match flags only.
  assign fixed_w = dec_code[DW-1:0] ^ match_w[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid         <= 1'b0;
      dec_data          <= '0;
      dec_corrected     <= 1'b0;
      dec_uncorrectable <= 1'b0;
    end else begin
      dec_valid <= dec_valid_in;
      if (dec_valid_in) begin
        dec_data          <= fixed_w;
        dec_corrected     <= single_w;
        dec_uncorrectable <= multi_w;
      end else begin
        dec_corrected     <= 1'b0;
        dec_uncorrectable <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk
  import secded_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          dec_valid_in,
  input logic [NW-1:0] dec_code,
  input logic          dec_valid,
  input logic [DW-1:0] dec_data,
  input logic          dec_corrected,
  input logic          dec_uncorrectable,
  input logic [CW-1:0] syn,
  input logic [NW-1:0] match
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_flag_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_corrected && dec_uncorrectable));

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (dec_valid == $past(dec_valid_in)));

  p_idle_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_corrected && !dec_uncorrectable));

  p_match_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  p_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_in && syn == '0) |=>
      (dec_data == $past(dec_code[DW-1:0]) && !dec_corrected && !dec_uncorrectable));

  p_even_syn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_in && syn != '0 && !(^syn)) |=> (dec_uncorrectable && !dec_corrected));

  p_check_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_in && $countones(syn) == 1) |=>
      (dec_corrected && dec_data == $past(dec_code[DW-1:0])));
endmodule

bind secded_codec secded_codec_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .dec_valid_in     (dec_valid_in),
  .dec_code         (dec_code),
  .dec_valid        (dec_valid),
  .dec_data         (dec_data),
  .dec_corrected    (dec_corrected),
  .dec_uncorrectable(dec_uncorrectable),
  .syn              (syn_w),
  .match            (match_w)
);

// File: tb/secded_codec_tb.sv
module secded_codec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] enc_data = '0;
  logic [38:0] enc_code;
  logic        dec_valid_in = 1'b0;
  logic [38:0] dec_code = '0;
  logic        dec_valid;
  logic [31:0] dec_data;
  logic        dec_corrected;
  logic        dec_uncorrectable;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [6:0] tcol [39];

  always #4 clk = ~clk;

  secded_codec u_dut (
    .clk(clk), .rst_n(rst_n), .enc_data(enc_data), .enc_code(enc_code),
    .dec_valid_in(dec_valid_in), .dec_code(dec_code), .dec_valid(dec_valid),
    .dec_data(dec_data), .dec_corrected(dec_corrected),
    .dec_uncorrectable(dec_uncorrectable)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_check(input logic [31:0] d);
    logic [6:0] c;
    c = '0;
    for (int i = 0; i < 32; i++) if (d[i]) c = c ^ tcol[i];
    return c;
  endfunction

  task automatic run_dec(input logic [38:0] cw, output logic [31:0] d,
                         output logic c, output logic u);
    @(negedge clk);
    dec_code = cw;
    dec_valid_in = 1'b1;
    @(negedge clk);
    d = dec_data;
    c = dec_corrected;
    u = dec_uncorrectable;
  endtask

  task automatic sweep_word(input logic [31:0] w);
    logic [38:0] cw;
    logic [31:0] d;
    logic c, u;
    enc_data = w;
    #1;
    cw = {ref_check(w), w};
    chk(enc_code == cw, "R1 encode", 64'(enc_code), 64'(cw));
    run_dec(cw, d, c, u);
    chk(d == w && !c && !u, "R3 clean", {29'd0, c, u, d}, {32'd0, w});
    for (int p = 0; p < 39; p++) begin
      run_dec(cw ^ (39'd1 << p), d, c, u);
      if (p < 32)
        chk(d == w && c && !u, "R4 data flip", {29'd0, c, u, d}, {29'd0, 1'b1, 1'b0, w});
      else
        chk(d == w && c && !u, "R5 check flip", {29'd0, c, u, d}, {29'd0, 1'b1, 1'b0, w});
      chk(!(c && u), "R10 exclusive", {62'd0, c, u}, 64'd0);
    end
    for (int n = 0; n < 40; n++) begin
      int a, b;
      a = int'($urandom % 39);
      b = (a + 1 + int'($urandom % 38)) % 39;
      run_dec(cw ^ (39'd1 << a) ^ (39'd1 << b), d, c, u);
      chk(u && !c, "R6 double", {62'd0, c, u}, 64'd1);
    end
  endtask

  initial begin
    int k;
    k = 0;
    for (int v = 1; v < 128; v++) begin
      int w;
      w = 0;
      for (int s = v; s != 0; s = s >> 1) w += s & 1;
      if (w == 3 && v != 7 && v != 56 && v != 97 && k < 32) begin
        tcol[k] = 7'(v);
        k++;
      end
    end
    for (int j = 0; j < 7; j++) tcol[32 + j] = 7'(1 << j);
  end

  initial begin
    logic [31:0] d;
    logic c, u;
    logic [38:0] cw;
    int rows [7];
    repeat (3) @(negedge clk);
    chk(dec_valid == 0 && dec_data == 0 && !dec_corrected && !dec_uncorrectable,
        "R9 reset", {30'd0, dec_valid, dec_corrected, dec_data}, 64'd0);
    rst_n = 1'b1;

    foreach (rows[j]) rows[j] = 0;
    for (int i = 0; i < 32; i++) begin
      enc_data = 32'd1 << i;
      #1;
      chk(enc_code[38:32] == tcol[i], "R1 column", 64'(enc_code[38:32]), 64'(tcol[i]));
      for (int j = 0; j < 7; j++) rows[j] += int'(enc_code[32 + j]);
    end
    for (int j = 0; j < 7; j++)
      chk(rows[j] == 13 || rows[j] == 14, "R2 row weight", 64'(rows[j]), 64'd13);

    // R8: latency from an idle decoder
    @(negedge clk);
    enc_data = 32'hA5C3_0F96;
    #1;
    cw = enc_code ^ (39'd1 << 17);
    dec_code = cw;
    dec_valid_in = 1'b1;
    #1;
    chk(dec_valid == 0, "R8 not before edge", 64'(dec_valid), 64'd0);
    @(negedge clk);
    chk(dec_valid == 1 && dec_data == 32'hA5C3_0F96 && dec_corrected, "R8 one cycle",
        {31'd0, dec_valid, dec_data}, {31'd1, 32'hA5C3_0F96});
    dec_valid_in = 1'b0;
    @(negedge clk);
    chk(dec_valid == 0 && !dec_corrected && !dec_uncorrectable, "R9 idle flags",
        {62'd0, dec_valid, dec_corrected}, 64'd0);

    // R7: odd-weight syndromes with no matching column
    enc_data = 32'h1357_9BDF;
    #1;
    run_dec(enc_code ^ {7'h07, 32'd0}, d, c, u);
    chk(u && !c && d == 32'h1357_9BDF, "R7 syndrome 7", {29'd0, c, u, d}, {30'd0, 1'b1, 32'h1357_9BDF});
    run_dec(enc_code ^ {7'h1F, 32'd0}, d, c, u);
    chk(u && !c && d == 32'h1357_9BDF, "R7 weight five", {29'd0, c, u, d}, {30'd0, 1'b1, 32'h1357_9BDF});

    sweep_word(32'h0000_0000);
    sweep_word(32'hFFFF_FFFF);
    for (int n = 0; n < 18; n++) sweep_word($urandom);
    dec_valid_in = 1'b0;
    @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule